// File: doc/BRIEF.md
# Grid Column Ray Caster

This block renders one vertical strip of a first-person view of a flat tile world. The world is a square grid held in an on-chip map, where each cell is either empty or holds one block. All blocks have the same height and footprint, have four vertical faces and no top or bottom, and carry a small texture code. For one screen column the block aims a ray, marches it through the grid in fixed-point steps, and stops at the first occupied cell or at a fixed step limit. It then emits the pixels of that column as beats. Each beat carries a screen row and a texel address. The strip starts at the vertical centre and grows outward one row above and one row below per iteration, and its height shrinks with the hit distance.

A caller loads the map through a cell write port, then pulses `start` with the player position in unsigned Q8.8 grid units, a facing angle and the column number. Every column takes the same number of cycles whatever the scene holds. Once a ray has hit or left the map, the unit stays frozen for the rest of the marching window. Rows beyond the scaled height are idle slots in a drawing window of fixed length. Many copies can therefore run in lock-step, one per column.

Top module: `gridColumnCaster`

## Requirements
- R1: After reset `done`, `hit` and `pixValid` are 0, and every map cell is empty (code 0).
- R2: The ray angle is `facing + column - COLS/2`, taken modulo 64, in units of 1/64 turn. The per-step direction is (round(256·cos), round(256·sin)) of that angle. Each step adds it to the Q8.8 position, with the sum wrapping at 16 bits. The integer part (bits 15:8) of each coordinate is the grid cell. The starting cell is never tested.
- R3: If step s (1 to 32) lands in a cell with a nonzero code, then `hit`=1, `hitDist`=s, `hitX`/`hitY` give that cell, and `hitTex` gives its code. No later step changes these results.
- R4: If no step up to 32 hits a block, or a step lands on a cell coordinate of 16 or more, the column is a miss. A miss gives `hit`=0 and `hitDist`=0, and no pixel beats are emitted.
- R5: `hitSide` is 0 when the hitting step changed the integer x cell and 1 otherwise. `pixTexel[7:4]` is bits 7:4 of the fractional part of y for side 0, and of x for side 1.
- R6: The half height is min(32, 64 / `hitDist`), using integer division.
- R7: For i = 0 up to halfHeight-1, the block emits row 31-i and then row 32+i. No other beats occur.
- R8: With vOff = (i · floor(2048/halfHeight)) >> 8, the upper row uses texel row 7-vOff and the lower row uses 8+vOff. `pixTexel` = {code[11:8], u[7:4], v[3:0]}.
- R9: `done` rises exactly 96 cycles after the cycle in which `start` is accepted, for any scene. It then stays high until the next start.
- R10: A `start` pulse that arrives while a column is in progress is ignored, and the results and beats of the running column do not change.
- R11: A cycle with `mapWe` high stores `mapWrData` into cell (`mapWrX`,`mapWrY`). Writing 0 makes the cell empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a column when idle or finished |
| posX | input | 16 | Player x, unsigned Q8.8 |
| posY | input | 16 | Player y, unsigned Q8.8 |
| facing | input | 6 | Facing angle, 1/64 turn units |
| column | input | 4 | Screen column index |
| mapWe | input | 1 | Map cell write strobe |
| mapWrX | input | 4 | Map write x cell |
| mapWrY | input | 4 | Map write y cell |
| mapWrData | input | 4 | Block code, 0 for empty |
| done | output | 1 | Column finished |
| hit | output | 1 | A block was struck |
| hitDist | output | 6 | Step number of the hit |
| hitSide | output | 1 | 0 for a face crossed in x, 1 for a face crossed in y |
| hitX | output | 4 | Struck cell x |
| hitY | output | 4 | Struck cell y |
| hitTex | output | 4 | Code of the struck block |
| pixValid | output | 1 | Pixel beat valid |
| pixRow | output | 6 | Screen row of the beat |
| pixTexel | output | 12 | Texel address {code, u, v} |

## Verification
A wrong step position or direction entry moves the reported hit distance or cell. This is visible at `done`, 96 cycles after start, and in the count of emitted beats. A stale halt flag or stepping that continues after a hit shows up as a larger `hitDist` or as a different `hitTex`. An error in the scale lookups or in the texture accumulator shows up on the very first beat pair or a few beats later, as a wrong row or a wrong texel row. A control-counter fault moves the rise of `done` away from the fixed 96-cycle latency.

// File: rtl/rcPkg.sv
package rcPkg;

  typedef enum logic [1:0] {ST_IDLE, ST_MARCH, ST_DRAW, ST_DONE} rcState_e;

  typedef struct packed {
    logic loadRay;
    logic marchEn;
    logic drawEn;
    logic lowerRow;
  } rcCtrl_t;

  // quarter-wave sine, 16 steps per quadrant, scaled by 256
  function automatic logic [8:0] quarterSin(input logic [4:0] k);
    case (k)
      5'd0:  quarterSin = 9'd0;
      5'd1:  quarterSin = 9'd25;
      5'd2:  quarterSin = 9'd50;
      5'd3:  quarterSin = 9'd74;
      5'd4:  quarterSin = 9'd98;
      5'd5:  quarterSin = 9'd121;
      5'd6:  quarterSin = 9'd142;
      5'd7:  quarterSin = 9'd162;
      5'd8:  quarterSin = 9'd181;
      5'd9:  quarterSin = 9'd198;
      5'd10: quarterSin = 9'd213;
      5'd11: quarterSin = 9'd226;
      5'd12: quarterSin = 9'd237;
      5'd13: quarterSin = 9'd245;
      5'd14: quarterSin = 9'd251;
      5'd15: quarterSin = 9'd255;
      default: quarterSin = 9'd256;
    endcase
  endfunction

endpackage

// File: rtl/rcCtrl.sv
module rcCtrl
  import rcPkg::*;
#(
  parameter int MAX_STEPS = 32,
  parameter int HALF_ROWS = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output rcCtrl_t ctrl,
  output logic [$clog2(2*HALF_ROWS)-2:0] rowIdx,
  output logic done
);
  localparam int SW = $clog2(MAX_STEPS);
  localparam int DW = $clog2(2*HALF_ROWS);

  rcState_e state;
  logic [SW-1:0] loopCnt;
  logic [DW-1:0] drawCnt;
  logic accept;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loopCnt <= '0;
      drawCnt <= '0;
    end else begin
      case (state)
        ST_MARCH: begin
          if (loopCnt == SW'(MAX_STEPS-1)) begin
            state   <= ST_DRAW;
            drawCnt <= '0;
          end else begin
            loopCnt <= loopCnt + 1'b1;
          end
        end
        ST_DRAW: begin
          if (drawCnt == DW'(2*HALF_ROWS-1)) state <= ST_DONE;
          else drawCnt <= drawCnt + 1'b1;
        end
        default: begin
          if (accept) begin
            state   <= ST_MARCH;
            loopCnt <= '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctrl.loadRay  = accept;
    ctrl.marchEn  = (state == ST_MARCH);
    ctrl.drawEn   = (state == ST_DRAW);
    ctrl.lowerRow = drawCnt[0];
  end

  assign rowIdx = drawCnt[DW-1:1];
  assign done   = (state == ST_DONE);

endmodule

// File: rtl/rcPath.sv
module rcPath
  import rcPkg::*;
#(
  parameter int MAP_DIM      = 16,
  parameter int CELL_W       = 4,
  parameter int MAX_STEPS    = 32,
  parameter int HALF_ROWS    = 32,
  parameter int COLS         = 16,
  parameter int TEX_DIM      = 16,
  parameter int HEIGHT_SCALE = 64
) (
  input  logic clk,
  input  logic rstN,
  input  rcCtrl_t ctrl,
  input  logic [$clog2(2*HALF_ROWS)-2:0] rowIdx,
  input  logic [15:0] posX,
  input  logic [15:0] posY,
  input  logic [5:0]  facing,
  input  logic [$clog2(COLS)-1:0] column,
  input  logic mapWe,
  input  logic [$clog2(MAP_DIM)-1:0] mapWrX,
  input  logic [$clog2(MAP_DIM)-1:0] mapWrY,
  input  logic [CELL_W-1:0] mapWrData,
  output logic hit,
  output logic [$clog2(MAX_STEPS+1)-1:0] hitDist,
  output logic hitSide,
  output logic [$clog2(MAP_DIM)-1:0] hitX,
  output logic [$clog2(MAP_DIM)-1:0] hitY,
  output logic [CELL_W-1:0] hitTex,
  output logic pixValid,
  output logic [$clog2(2*HALF_ROWS)-1:0] pixRow,
  output logic [CELL_W+2*$clog2(TEX_DIM)-1:0] pixTexel
);
  localparam int MW     = $clog2(MAP_DIM);
  localparam int TW     = $clog2(TEX_DIM);
  localparam int DIST_W = $clog2(MAX_STEPS+1);
  localparam int HW     = $clog2(HALF_ROWS+1);
  localparam int ROW_W  = $clog2(2*HALF_ROWS);
  localparam int IDX_W  = ROW_W - 1;
  localparam int FRAC   = 8;
  localparam int ACC_W  = FRAC + TW;

  // map storage
  logic [CELL_W-1:0] mapMem [MAP_DIM*MAP_DIM];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAP_DIM*MAP_DIM; i++) mapMem[i] <= '0;
    end else if (mapWe) begin
      mapMem[{mapWrY, mapWrX}] <= mapWrData;
    end
  end

  // ray direction
  logic [5:0]  rayAng;
  logic [8:0]  sinA, sinB;
  logic [15:0] dirXc, dirYc;

  always_comb begin
    rayAng = facing + 6'(column) - 6'(COLS/2);
    sinA   = quarterSin({1'b0, rayAng[3:0]});
    sinB   = quarterSin(5'd16 - {1'b0, rayAng[3:0]});
    case (rayAng[5:4])
      2'd0: begin dirXc = 16'(sinB);         dirYc = 16'(sinA);         end
      2'd1: begin dirXc = 16'd0 - 16'(sinA); dirYc = 16'(sinB);         end
      2'd2: begin dirXc = 16'd0 - 16'(sinB); dirYc = 16'd0 - 16'(sinA); end
      default: begin dirXc = 16'(sinA);      dirYc = 16'd0 - 16'(sinB); end
    endcase
  end

  // marching
  logic [15:0] dirX, dirY, curX, curY, nX, nY;
  logic [DIST_W-1:0] stepNo;
  logic halted;
  logic outOfMap;
  logic [CELL_W-1:0] cellVal;
  logic [TW-1:0] texU;

  assign nX = curX + dirX;
  assign nY = curY + dirY;
  assign outOfMap = (nX[15:8] >= 8'(MAP_DIM)) || (nY[15:8] >= 8'(MAP_DIM));
  assign cellVal  = outOfMap ? '0 : mapMem[{nY[MW-1+8:8], nX[MW-1+8:8]}];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirX <= '0; dirY <= '0; curX <= '0; curY <= '0;
      stepNo <= '0; halted <= 1'b0; hit <= 1'b0; hitDist <= '0;
      hitSide <= 1'b0; hitX <= '0; hitY <= '0; hitTex <= '0; texU <= '0;
    end else if (ctrl.loadRay) begin
      dirX <= dirXc; dirY <= dirYc; curX <= posX; curY <= posY;
      stepNo <= '0; halted <= 1'b0; hit <= 1'b0; hitDist <= '0;
      hitSide <= 1'b0; hitX <= '0; hitY <= '0; hitTex <= '0; texU <= '0;
    end else if (ctrl.marchEn && !halted) begin
      curX   <= nX;
      curY   <= nY;
      stepNo <= stepNo + 1'b1;
      if (outOfMap) begin
        halted <= 1'b1;
      end else if (cellVal != '0) begin
        halted  <= 1'b1;
        hit     <= 1'b1;
        hitDist <= stepNo + 1'b1;
        hitX    <= nX[MW-1+8:8];
        hitY    <= nY[MW-1+8:8];
        hitTex  <= cellVal;
        if (nX[15:8] != curX[15:8]) begin
          hitSide <= 1'b0;
          texU    <= nY[7:8-TW];
        end else begin
          hitSide <= 1'b1;
          texU    <= nX[7:8-TW];
        end
      end
    end
  end

  // scale lookups, computed at elaboration
  logic [HW-1:0]    halfLut [MAX_STEPS+1];
  logic [ACC_W-1:0] stepLut [HALF_ROWS+1];

  for (genvar g = 0; g <= MAX_STEPS; g++) begin : gHalf
    localparam int Q = (g == 0) ? 0 : HEIGHT_SCALE / g;
    assign halfLut[g] = HW'((Q > HALF_ROWS) ? HALF_ROWS : Q);
  end

  for (genvar g = 0; g <= HALF_ROWS; g++) begin : gStep
    localparam int SV = (g == 0) ? 0 : (TEX_DIM * 128) / g;
    assign stepLut[g] = ACC_W'(SV);
  end

  logic [HW-1:0]    halfH;
  logic [ACC_W-1:0] stepV, acc;
  logic [TW-1:0]    vOff, texV;

  assign halfH = hit ? halfLut[hitDist] : '0;
  assign stepV = stepLut[halfH];
  assign vOff  = acc[ACC_W-1:FRAC];

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.loadRay) acc <= '0;
    else if (ctrl.drawEn && ctrl.lowerRow) acc <= acc + stepV;
  end

  // beat outputs
  logic [IDX_W-1:0] idx;
  assign idx = rowIdx;

  always_comb begin
    pixValid = ctrl.drawEn && hit && (HW'(idx) < halfH);
    if (ctrl.lowerRow) begin
      pixRow = ROW_W'(HALF_ROWS) + ROW_W'(idx);
      texV   = TW'(TEX_DIM/2) + vOff;
    end else begin
      pixRow = ROW_W'(HALF_ROWS-1) - ROW_W'(idx);
      texV   = TW'(TEX_DIM/2-1) - vOff;
    end
    pixTexel = {hitTex, texU, texV};
  end

endmodule

// File: rtl/gridColumnCaster.sv
module gridColumnCaster
  import rcPkg::*;
#(
  parameter int MAP_DIM      = 16,
  parameter int CELL_W       = 4,
  parameter int MAX_STEPS    = 32,
  parameter int HALF_ROWS    = 32,
  parameter int COLS         = 16,
  parameter int TEX_DIM      = 16,
  parameter int HEIGHT_SCALE = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [15:0] posX,
  input  logic [15:0] posY,
  input  logic [5:0] facing,
  input  logic [$clog2(COLS)-1:0] column,
  input  logic mapWe,
  input  logic [$clog2(MAP_DIM)-1:0] mapWrX,
  input  logic [$clog2(MAP_DIM)-1:0] mapWrY,
  input  logic [CELL_W-1:0] mapWrData,
  output logic done,
  output logic hit,
  output logic [$clog2(MAX_STEPS+1)-1:0] hitDist,
  output logic hitSide,
  output logic [$clog2(MAP_DIM)-1:0] hitX,
  output logic [$clog2(MAP_DIM)-1:0] hitY,
  output logic [CELL_W-1:0] hitTex,
  output logic pixValid,
  output logic [$clog2(2*HALF_ROWS)-1:0] pixRow,
  output logic [CELL_W+2*$clog2(TEX_DIM)-1:0] pixTexel
);
  rcCtrl_t ctrl;
  logic [$clog2(2*HALF_ROWS)-2:0] rowIdx;

  rcCtrl #(.MAX_STEPS(MAX_STEPS), .HALF_ROWS(HALF_ROWS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctrl(ctrl), .rowIdx(rowIdx), .done(done)
  );

  rcPath #(
    .MAP_DIM(MAP_DIM), .CELL_W(CELL_W), .MAX_STEPS(MAX_STEPS),
    .HALF_ROWS(HALF_ROWS), .COLS(COLS), .TEX_DIM(TEX_DIM),
    .HEIGHT_SCALE(HEIGHT_SCALE)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rowIdx(rowIdx),
    .posX(posX), .posY(posY), .facing(facing), .column(column),
    .mapWe(mapWe), .mapWrX(mapWrX), .mapWrY(mapWrY), .mapWrData(mapWrData),
    .hit(hit), .hitDist(hitDist), .hitSide(hitSide), .hitX(hitX), .hitY(hitY),
    .hitTex(hitTex), .pixValid(pixValid), .pixRow(pixRow), .pixTexel(pixTexel)
  );

endmodule

// File: rtl/gridColumnCasterChk.sv
module gridColumnCasterChk #(
  parameter int MAX_STEPS = 32,
  parameter int HALF_ROWS = 32,
  parameter int DIST_W    = 6,
  parameter int ROW_W     = 6,
  parameter int TEXEL_W   = 12,
  parameter int CELL_W    = 4,
  parameter int TEX_DIM   = 16
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic done,
  input logic hit,
  input logic [DIST_W-1:0] hitDist,
  input logic [CELL_W-1:0] hitTex,
  input logic pixValid,
  input logic [ROW_W-1:0] pixRow,
  input logic [TEXEL_W-1:0] pixTexel
);
  localparam int TW = $clog2(TEX_DIM);

  AST_BEAT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (hit && hitDist != '0)); // R4

  AST_DIST_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (hitDist >= 1 && hitDist <= DIST_W'(MAX_STEPS))); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R9

  AST_NO_BEAT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pixValid); // R9

  AST_UPPER_TEXEL_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixRow < ROW_W'(HALF_ROWS)) |-> (pixTexel[TW-1:0] < TW'(TEX_DIM/2))); // R8

  AST_TEX_STABLE_IN_DRAW: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid)) |-> $stable(hitTex)); // R7

endmodule

bind gridColumnCaster gridColumnCasterChk #(
  .MAX_STEPS(MAX_STEPS), .HALF_ROWS(HALF_ROWS),
  .DIST_W($clog2(MAX_STEPS+1)), .ROW_W($clog2(2*HALF_ROWS)),
  .TEXEL_W(CELL_W+2*$clog2(TEX_DIM)), .CELL_W(CELL_W), .TEX_DIM(TEX_DIM)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .hit(hit),
  .hitDist(hitDist), .hitTex(hitTex), .pixValid(pixValid),
  .pixRow(pixRow), .pixTexel(pixTexel)
);

// File: tb/gridColumnCaster_test.sv
`timescale 1ns/1ps
module gridColumnCaster_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] posX = '0, posY = '0;
  logic [5:0] facing = '0;
  logic [3:0] column = '0;
  logic mapWe = 1'b0;
  logic [3:0] mapWrX = '0, mapWrY = '0, mapWrData = '0;
  logic done, hit, hitSide, pixValid;
  logic [5:0] hitDist, pixRow;
  logic [3:0] hitX, hitY, hitTex;
  logic [11:0] pixTexel;

  int checks = 0, failures = 0;
  bit finished = 0;
  int mapM [16][16];

  int eHit, eDist, eSide, eX, eY, eTex, eU, eHalf, eStep;

  always #2.5 clk = ~clk;

  gridColumnCaster uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int comp(input int ang, input bit isSin);
    real th, r;
    th = ang * 2.0 * 3.14159265358979 / 64.0;
    r = 256.0 * (isSin ? $sin(th) : $cos(th));
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  // expected result from the requirements (R2..R6)
  task automatic model(input int px, input int py, input int fac, input int col);
    int ang, dx, dy, cx, cy, nx, ny, gx, gy;
    ang = (fac + col - 8) & 63;
    dx = comp(ang, 0);
    dy = comp(ang, 1);
    cx = px; cy = py;
    eHit = 0; eDist = 0; eSide = 0; eX = 0; eY = 0; eTex = 0; eU = 0;
    for (int s = 1; s <= 32; s++) begin
      nx = (cx + dx) & 65535;
      ny = (cy + dy) & 65535;
      gx = nx >> 8; gy = ny >> 8;
      if (gx >= 16 || gy >= 16) break;
      if (mapM[gx][gy] != 0) begin
        eHit = 1; eDist = s; eX = gx; eY = gy; eTex = mapM[gx][gy];
        eSide = (gx != (cx >> 8)) ? 0 : 1;
        eU = (eSide == 0) ? ((ny >> 4) & 15) : ((nx >> 4) & 15);
        break;
      end
      cx = nx; cy = ny;
    end
    eHalf = eHit ? ((64 / eDist > 32) ? 32 : 64 / eDist) : 0;
    eStep = eHalf ? 2048 / eHalf : 0;
  endtask

  task automatic writeCell(input int x, input int y, input int v);
    @(negedge clk);
    mapWe = 1; mapWrX = 4'(x); mapWrY = 4'(y); mapWrData = 4'(v);
    @(negedge clk);
    mapWe = 0;
    mapM[x][y] = v;
  endtask

  task automatic runColumn(input int px, input int py, input int fac, input int col,
                           input int injectAt);
    int n, beats, i, vo, expRow, expV, expTexel;
    model(px, py, fac, col);
    @(negedge clk);
    posX = 16'(px); posY = 16'(py); facing = 6'(fac); column = 4'(col);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0; beats = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      start = (n == injectAt);
      if (n == injectAt) posX = posX ^ 16'h0300;
      if (pixValid) begin
        i = beats / 2;
        vo = (i * eStep) >> 8;
        expRow = (beats % 2) ? 32 + i : 31 - i;
        expV = (beats % 2) ? 8 + vo : 7 - vo;
        expTexel = (eTex << 8) | (eU << 4) | expV;
        check(int'(pixRow) == expRow, "R7 row", pixRow, expRow);
        check(int'(pixTexel) == expTexel, "R8 texel", pixTexel, expTexel);
        beats++;
      end
    end
    start = 0;
    check(n == 96, "R9 latency", n, 96);
    check(int'(hit) == eHit, "R3 R4 hit", hit, eHit);
    check(int'(hitDist) == eDist, "R3 R4 dist", hitDist, eDist);
    check(beats == 2 * eHalf, "R6 R7 beat count", beats, 2 * eHalf);
    if (eHit) begin
      check(int'(hitX) == eX && int'(hitY) == eY, "R3 cell", {hitX, hitY}, eX * 16 + eY);
      check(int'(hitTex) == eTex, "R3 tex", hitTex, eTex);
      check(int'(hitSide) == eSide, "R5 side", hitSide, eSide);
    end
    @(negedge clk);
    check(done == 1'b1, "R9 done held", done, 1);
  endtask

  initial begin
    for (int x = 0; x < 16; x++) for (int y = 0; y < 16; y++) mapM[x][y] = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(done == 0 && hit == 0 && pixValid == 0, "R1 reset outputs", {done, hit, pixValid}, 0);
    // R1: empty map after reset, ray leaves the map -> miss
    runColumn(16'h0280, 16'h0280, 0, 8, 0);
    // R11: write a block, hit at distance 1
    writeCell(3, 2, 5);
    runColumn(16'h0280, 16'h0280, 0, 8, 0);
    check(hitDist == 1 && hitTex == 5, "R11 written cell", hitTex, 5);
    // distance 3 (clipped scale gone)
    writeCell(3, 2, 0);
    writeCell(5, 2, 9);
    runColumn(16'h0280, 16'h0280, 0, 8, 0);
    // y-face and angled ray
    writeCell(2, 6, 3);
    runColumn(16'h0280, 16'h0280, 16, 8, 0);
    runColumn(16'h0240, 16'h0250, 10, 5, 0);
    // R10: start during a run is ignored
    runColumn(16'h0280, 16'h0280, 0, 8, 20);
    runColumn(16'h0280, 16'h0280, 0, 8, 60);
    // R11: clearing cell makes it empty again
    writeCell(5, 2, 0);
    runColumn(16'h0280, 16'h0280, 0, 8, 0);
    check(hit == 0, "R11 cleared cell", hit, 0);
    // random scenes
    for (int t = 0; t < 40; t++) begin
      if (t % 8 == 0) begin
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            if (($urandom % 100) < 12) writeCell(x, y, 1 + ($urandom % 15));
            else if (mapM[x][y] != 0) writeCell(x, y, 0);
      end
      runColumn((($urandom % 14 + 1) << 8) | ($urandom % 256),
                (($urandom % 14 + 1) << 8) | ($urandom % 256),
                $urandom % 64, $urandom % 16, 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule